// File: doc/BRIEF.md
# Keyed Configuration Blob Server

A memory-mapped peripheral from which boot firmware fetches small configuration blobs by a 16-bit key. Software writes a key to a selector register and then streams the chosen blob through a data register, one byte or a packed group of bytes per access. Selecting a key also rewinds the blob's byte cursor to zero. The blob table is fixed by parameters. It holds a four-byte identification signature, a four-byte interface revision word (currently zero), a read-only pattern blob and a writable scratch blob. The writable blob can be overwritten through the data register in the same streaming order that reads use.

The bus side has two valid/ready channels. A request carries a write flag, a register offset, byte enables and write data. Every accepted request produces exactly one response one cycle later, and the response carries read data for reads and zero for writes. Back-pressure rule: a new request is accepted only when the response slot is empty or is being drained in the same cycle (`req_ready = !resp_valid || resp_ready`). A response held by a low `resp_ready` keeps its data unchanged. A wide access finishes in one cycle: all of its lanes are served at once from consecutive cursor positions.

Top module: `cfg_blob_server`

## Requirements
- R1: After reset the selected key is 0x0000, the cursor is 0, `resp_valid` is low and `req_ready` is high.
- R2: A write to offset 8 with `req_be[1:0]==2'b11` selects a new key, taken big-endian: key = {wdata[7:0], wdata[15:8]}. The write sets the cursor to 0. A selector write with any other byte-enable pattern, and any read of offset 8, has no effect and responds 0.
- R3: A read at offset 0 with byte enables 8'h01, 8'h03, 8'h0F or 8'hFF (width 1, 2, 4 or 8 bytes) returns stream bytes cursor..cursor+width-1 in lanes 0..width-1 (lane i = rdata[8i+7:8i]). Unused lanes are 0. The cursor advances by the width.
- R4: Stream positions at or beyond the blob length, and every position of an undefined key, read as 0x00. The cursor never moves past the blob length.
- R5: Key 0x0000 streams the signature bytes 0x43, 0x46, 0x47, 0x42 in that order. Key 0x0001 streams four bytes of a little-endian 32-bit revision word whose value is 0.
- R6: Key 0x0020 is a writable 16-byte blob that resets to zeros. A data write with a legal width stores wdata lane i at stream position cursor+i and advances the cursor. Lanes that fall beyond the end are dropped.
- R7: Key 0x0021 is a read-only 24-byte blob whose byte k is (13k+5) mod 256. Data writes to it, and data writes to any key other than 0x0020, leave the contents and the cursor unchanged.
- R8: Accesses at offsets other than 0 and 8, and data accesses at offset 0 with any byte-enable pattern outside R3's four, respond 0 and change neither key, cursor nor contents.
- R9: `req_ready = !resp_valid || resp_ready`. Each accepted request yields one response in the next cycle. While `resp_valid && !resp_ready`, `resp_valid` and `resp_rdata` stay stable.
- R10: Responses to write requests carry `resp_rdata == 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Register byte offset: 0 data, 8 selector |
| req_be | input | 8 | Byte enables, lane i = bits 8i+7:8i |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumed when high together with resp_valid |
| resp_rdata | output | 64 | Read data, 0 for writes and ignored accesses |

## Verification
Two things can happen in one clock edge: the drain of a finished response and the acceptance of the next data access, which moves the cursor. The bench sets this up with back-to-back reads while `resp_ready` stays high. It then checks that the second response holds the bytes that follow the first, with no byte repeated or skipped. Constrained-random traffic also holds responses under back-pressure for several cycles. During that time it checks that the held data does not change and that the cursor does not move, by comparing every later read against a reference model of key, cursor and scratch contents.

// File: rtl/cfg_blob_pkg.sv
package cfg_blob_pkg;

  typedef enum logic [2:0] {
    ENT_SIG  = 3'd0,
    ENT_REV  = 3'd1,
    ENT_RAM  = 3'd2,
    ENT_ROM  = 3'd3,
    ENT_NONE = 3'd4
  } entry_e;

  localparam int LANES = 8;

  // Legal data widths in bytes; 0 marks an unsupported enable pattern.
  function automatic logic [3:0] be_width(input logic [7:0] be);
    case (be)
      8'h01:   return 4'd1;
      8'h03:   return 4'd2;
      8'h0F:   return 4'd4;
      8'hFF:   return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] rom_byte(input logic [31:0] k);
    logic [31:0] v;
    v = k * 32'd13 + 32'd5;
    return v[7:0];
  endfunction

endpackage

// File: rtl/cfg_key_lookup.sv
module cfg_key_lookup
  import cfg_blob_pkg::*;
#(
  parameter logic [15:0] KEY_RAM   = 16'h0020,
  parameter logic [15:0] KEY_ROM   = 16'h0021,
  parameter int          RAM_BYTES = 16,
  parameter int          ROM_BYTES = 24,
  parameter int          POS_W     = 9
) (
  input  logic [15:0]      key,
  output entry_e           ent,
  output logic [POS_W-1:0] len,
  output logic             writable
);

  always_comb begin
    ent      = ENT_NONE;
    len      = '0;
    writable = 1'b0;
    if (key == 16'h0000) begin
      ent = ENT_SIG;
      len = POS_W'(4);
    end else if (key == 16'h0001) begin
      ent = ENT_REV;
      len = POS_W'(4);
    end else if (key == KEY_RAM) begin
      ent      = ENT_RAM;
      len      = POS_W'(RAM_BYTES);
      writable = 1'b1;
    end else if (key == KEY_ROM) begin
      ent = ENT_ROM;
      len = POS_W'(ROM_BYTES);
    end
  end

endmodule

// File: rtl/cfg_blob_store.sv
module cfg_blob_store
  import cfg_blob_pkg::*;
#(
  parameter int          RAM_BYTES = 16,
  parameter int          ROM_BYTES = 24,
  parameter logic [31:0] SIG       = 32'h43464742,
  parameter logic [31:0] REV       = 32'h0,
  parameter int          POS_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  entry_e               ent,
  input  logic [POS_W-1:0]     len,
  input  logic [POS_W-1:0]     base,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     wr_mask,
  input  logic [LANES*8-1:0]   wdata,
  output logic [LANES*8-1:0]   rd_bytes
);

  logic [7:0] mem [RAM_BYTES];

  // Scratch blob: lane i lands at stream position base+i.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < RAM_BYTES; j++) mem[j] <= '0;
    end else if (wr_en && ent == ENT_RAM) begin
      for (int i = 0; i < LANES; i++) begin
        for (int j = 0; j < RAM_BYTES; j++) begin
          if (wr_mask[i] && (base + POS_W'(i)) == POS_W'(j))
            mem[j] <= wdata[8*i +: 8];
        end
      end
    end
  end

  // One byte reader per lane, each at its own stream position.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [POS_W-1:0] pos;
    logic [7:0]       b;
    always_comb begin
      pos = base + POS_W'(g);
      b   = '0;
      if (pos < len) begin
        case (ent)
          ENT_SIG: for (int k = 0; k < 4; k++) if (pos == POS_W'(k)) b = SIG[31-8*k -: 8];
          ENT_REV: for (int k = 0; k < 4; k++) if (pos == POS_W'(k)) b = REV[8*k +: 8];
          ENT_RAM: for (int j = 0; j < RAM_BYTES; j++) if (pos == POS_W'(j)) b = mem[j];
          ENT_ROM: b = rom_byte(32'(pos));
          default: b = '0;
        endcase
      end
    end
    assign rd_bytes[8*g +: 8] = b;
  end

endmodule

// File: rtl/cfg_lane_pack.sv
module cfg_lane_pack
  import cfg_blob_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic [3:0]         width,
  input  logic [POS_W-1:0]   cursor,
  input  logic [POS_W-1:0]   len,
  input  logic [LANES*8-1:0] rd_bytes,
  output logic [LANES*8-1:0] rdata,
  output logic [LANES-1:0]   lane_mask,
  output logic [POS_W-1:0]   adv
);

  logic [POS_W-1:0] remaining;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g]        = (4'(g) < width);
    assign rdata[8*g +: 8]     = lane_mask[g] ? rd_bytes[8*g +: 8] : 8'h00;
  end

  always_comb begin
    remaining = (cursor < len) ? (len - cursor) : '0;
    adv       = (POS_W'(width) < remaining) ? POS_W'(width) : remaining;
  end

endmodule

// File: rtl/cfg_blob_server.sv
module cfg_blob_server
  import cfg_blob_pkg::*;
#(
  parameter int          RAM_BYTES = 16,
  parameter int          ROM_BYTES = 24,
  parameter logic [15:0] KEY_RAM   = 16'h0020,
  parameter logic [15:0] KEY_ROM   = 16'h0021,
  parameter logic [31:0] SIG       = 32'h43464742,
  parameter logic [31:0] REV       = 32'h0,
  parameter int          ADDR_W    = 4,
  parameter int          SEL_OFF   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_be,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [63:0]       resp_rdata
);

  localparam int MAX_A   = (RAM_BYTES > ROM_BYTES) ? RAM_BYTES : ROM_BYTES;
  localparam int MAX_LEN = (MAX_A > 4) ? MAX_A : 4;
  localparam int CUR_W   = $clog2(MAX_LEN + 1);
  localparam int POS_W   = CUR_W + 4;

  logic [15:0]      key_q;
  logic [POS_W-1:0] cur_q;
  entry_e           ent;
  logic [POS_W-1:0] blob_len;
  logic             writable;
  logic [63:0]      rd_bytes;
  logic [63:0]      packed_rd;
  logic [7:0]       lane_mask;
  logic [POS_W-1:0] adv;
  logic [3:0]       width;
  logic             acc, is_data, is_sel, rd_go, wr_go, sel_go;

  assign req_ready = !resp_valid || resp_ready;
  assign acc       = req_valid && req_ready;
  assign width     = be_width(req_be);
  assign is_data   = (req_addr == '0) && (width != 4'd0);
  assign is_sel    = (req_addr == ADDR_W'(SEL_OFF));
  assign rd_go     = acc && is_data && !req_write;
  assign wr_go     = acc && is_data && req_write && writable;
  assign sel_go    = acc && is_sel && req_write && (req_be[1:0] == 2'b11);

  cfg_key_lookup #(
    .KEY_RAM(KEY_RAM), .KEY_ROM(KEY_ROM),
    .RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES), .POS_W(POS_W)
  ) u_lookup (
    .key(key_q), .ent(ent), .len(blob_len), .writable(writable)
  );

  cfg_blob_store #(
    .RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES),
    .SIG(SIG), .REV(REV), .POS_W(POS_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .ent(ent), .len(blob_len), .base(cur_q),
    .wr_en(wr_go), .wr_mask(lane_mask), .wdata(req_wdata), .rd_bytes(rd_bytes)
  );

  cfg_lane_pack #(.POS_W(POS_W)) u_pack (
    .width(width), .cursor(cur_q), .len(blob_len), .rd_bytes(rd_bytes),
    .rdata(packed_rd), .lane_mask(lane_mask), .adv(adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= 16'h0000;
      cur_q <= '0;
    end else if (sel_go) begin
      key_q <= {req_wdata[7:0], req_wdata[15:8]};
      cur_q <= '0;
    end else if (rd_go || wr_go) begin
      cur_q <= cur_q + adv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else if (acc) begin
      resp_valid <= 1'b1;
      resp_rdata <= rd_go ? packed_rd : 64'h0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_blob_server_chk.sv
module cfg_blob_server_chk #(
  parameter int ADDR_W = 4,
  parameter int POS_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_be,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [63:0]       resp_rdata,
  input logic [POS_W-1:0]  cursor,
  input logic [POS_W-1:0]  blob_len
);

  logic accepted, legal_be;
  assign accepted = req_valid && req_ready;
  assign legal_be = (req_be == 8'h01) || (req_be == 8'h03) ||
                    (req_be == 8'h0F) || (req_be == 8'hFF);

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> resp_valid);

  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)));

  p_ready_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> req_ready);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && !accepted) |=> !resp_valid);

  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_write) |=> (resp_rdata == 64'h0));

  p_bad_be_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !req_write && req_addr == '0 && !legal_be) |=> (resp_rdata == 64'h0));

  p_bad_off_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_addr != '0 && req_addr != ADDR_W'(8)) |=> $stable(cursor));

  p_sel_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_write && req_addr == ADDR_W'(8) && req_be[1:0] == 2'b11) |=> (cursor == '0));

  p_cursor_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cursor <= blob_len);

endmodule

bind cfg_blob_server cfg_blob_server_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
  .cursor(cur_q), .blob_len(blob_len)
);

// File: tb/sim_cfg_blob_server.sv
`timescale 1ns/1ps
module sim_cfg_blob_server;

  localparam int          RAM_BYTES = 16;
  localparam int          ROM_BYTES = 24;
  localparam logic [15:0] KEY_RAM   = 16'h0020;
  localparam logic [15:0] KEY_ROM   = 16'h0021;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [63:0] resp_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] mkey;
  int          mcur;
  logic [7:0]  mram [RAM_BYTES];

  always #5 clk = ~clk;

  cfg_blob_server #(
    .RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES),
    .KEY_RAM(KEY_RAM), .KEY_ROM(KEY_ROM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int mlen(input logic [15:0] k);
    if (k == 16'h0000 || k == 16'h0001) return 4;
    if (k == KEY_RAM) return RAM_BYTES;
    if (k == KEY_ROM) return ROM_BYTES;
    return 0;
  endfunction

  function automatic logic [7:0] mbyte(input logic [15:0] k, input int p);
    logic [7:0] sig [4];
    sig = '{8'h43, 8'h46, 8'h47, 8'h42};
    if (p >= mlen(k)) return 8'h00;
    if (k == 16'h0000) return sig[p];
    if (k == KEY_RAM) return mram[p];
    if (k == KEY_ROM) return 8'((p * 13 + 5) % 256);
    return 8'h00;
  endfunction

  function automatic int bw(input logic [7:0] be);
    case (be)
      8'h01: return 1; 8'h03: return 2; 8'h0F: return 4; 8'hFF: return 8;
      default: return 0;
    endcase
  endfunction

  // Reference model of one access; returns the expected response data.
  function automatic logic [63:0] model(input bit wr, input logic [3:0] a,
                                        input logic [7:0] be, input logic [63:0] wd);
    logic [63:0] e = '0;
    int n = bw(be);
    int l = mlen(mkey);
    if (a == 4'd8 && wr && be[1:0] == 2'b11) begin
      mkey = {wd[7:0], wd[15:8]};
      mcur = 0;
    end else if (a == 4'd0 && n != 0) begin
      if (!wr) begin
        for (int i = 0; i < n; i++) e[8*i +: 8] = mbyte(mkey, mcur + i);
        mcur = (mcur + n < l) ? mcur + n : l;
      end else if (mkey == KEY_RAM) begin
        for (int i = 0; i < n; i++) if (mcur + i < l) mram[mcur + i] = wd[8*i +: 8];
        mcur = (mcur + n < l) ? mcur + n : l;
      end
    end
    return e;
  endfunction

  task automatic op(input string tag, input bit wr, input logic [3:0] a,
                    input logic [7:0] be, input logic [63:0] wd, input int stall);
    logic [63:0] exp, got;
    exp = model(wr, a, be, wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    resp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R9 resp"}, {63'h0, resp_valid}, 64'h1);
    got = resp_rdata;
    check(tag, got, exp);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      check({tag, " R9 held"}, resp_rdata, got);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic sel(input string tag, input logic [15:0] k);
    op(tag, 1'b1, 4'd8, 8'h03, {48'h0, k[7:0], k[15:8]}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e2;
    void'($urandom(32'd20240611));
    mkey = 16'h0000; mcur = 0;
    for (int j = 0; j < RAM_BYTES; j++) mram[j] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid idle", {63'h0, resp_valid}, 64'h0);
    check("R1 R9 ready idle", {63'h0, req_ready}, 64'h1);

    op("R1 R5 signature", 1'b0, 4'd0, 8'h0F, 64'h0, 0);
    op("R4 past end", 1'b0, 4'd0, 8'h01, 64'h0, 0);
    sel("R2 select rev", 16'h0001);
    op("R5 revision", 1'b0, 4'd0, 8'hFF, 64'h0, 2);
    sel("R2 select rom", KEY_ROM);
    op("R3 rom w2", 1'b0, 4'd0, 8'h03, 64'h0, 0);
    op("R7 rom write ignored", 1'b1, 4'd0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    op("R3 R7 rom after write", 1'b0, 4'd0, 8'hFF, 64'h0, 0);
    op("R8 offset 3", 1'b0, 4'd3, 8'h01, 64'h0, 0);
    op("R8 bad be", 1'b0, 4'd0, 8'h07, 64'h0, 0);
    op("R2 sel bad be", 1'b1, 4'd8, 8'h01, 64'h0000_0000_0000_0021, 0);
    op("R3 rom w8", 1'b0, 4'd0, 8'hFF, 64'h0, 0);
    op("R4 rom straddle", 1'b0, 4'd0, 8'hFF, 64'h0, 0);
    op("R4 rom end", 1'b0, 4'd0, 8'h0F, 64'h0, 0);
    sel("R2 select ram", KEY_RAM);
    op("R6 R10 ram wr8", 1'b1, 4'd0, 8'hFF, 64'h0807_0605_0403_0201, 0);
    op("R6 ram wr4", 1'b1, 4'd0, 8'h0F, 64'h0000_0000_DDCC_BBAA, 0);
    op("R6 ram wr8 straddle", 1'b1, 4'd0, 8'hFF, 64'h7766_5544_3322_1100, 0);
    sel("R2 reselect ram", KEY_RAM);
    op("R6 ram rd", 1'b0, 4'd0, 8'hFF, 64'h0, 0);
    op("R6 ram rd2", 1'b0, 4'd0, 8'hFF, 64'h0, 0);
    sel("R4 undefined key", 16'h1234);
    op("R4 undefined read", 1'b0, 4'd0, 8'hFF, 64'h0, 0);

    // Drain and accept in the same edge: two back-to-back reads.
    sel("R2 select rom b2b", KEY_ROM);
    e1 = model(1'b0, 4'd0, 8'h03, 64'h0);
    e2 = model(1'b0, 4'd0, 8'h03, 64'h0);
    @(negedge clk);
    resp_ready = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd0; req_be = 8'h03;
    @(negedge clk);
    check("R9 b2b first", resp_rdata, e1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 R9 b2b second", resp_rdata, e2);
    @(negedge clk);
    resp_ready = 1'b0;

    for (int t = 0; t < 400; t++) begin
      int r = $urandom % 10;
      logic [7:0] bes [4];
      logic [15:0] keys [5];
      logic [63:0] wd;
      logic [3:0] a;
      bes  = '{8'h01, 8'h03, 8'h0F, 8'hFF};
      keys = '{16'h0000, 16'h0001, KEY_RAM, KEY_ROM, 16'(16'h0100 + ($urandom % 4))};
      wd   = {$urandom, $urandom};
      if (r < 2) sel("R2 rnd select", keys[$urandom % 5]);
      else if (r < 6) op("R3 rnd read", 1'b0, 4'd0, bes[$urandom % 4], 64'h0, $urandom % 3);
      else if (r < 8) op("R6 rnd write", 1'b1, 4'd0, bes[$urandom % 4], wd, $urandom % 2);
      else if (r == 8) begin
        a = 4'(1 + ($urandom % 15));
        if (a == 4'd8) a = 4'd9;
        op("R8 rnd offset", 1'($urandom % 2), a, 8'hFF, wd, 0);
      end else begin
        op("R8 rnd bad be", 1'($urandom % 2), 4'd0, 8'h05, wd, 0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule